// File: doc/BRIEF.md
# Multi-Lane Serial Result Shifter

This block is the device-side serial read-out of a six-channel converter. It sends six result words of one frame over up to three serial data lanes. The channels are grouped in pairs A, B and C, each holding channels 0 and 1. The lane-select inputs decide how many lanes carry data and how the channels are spread over them, down to a single lane that carries all six words. A frame starts when the frame-sync input falls. Each selected lane then drives its words, most significant bit first, and moves on one bit after every rising serial-clock edge. When frame sync returns high, every lane's output enable drops.

In chain mode, each selected lane forwards the bits it receives from an upstream device on its own chain input once its local words are out. Several devices can then share one set of lanes. In the same frame, a serial input line is shifted into a 32-bit holding register. The holding register is copied into a control word only when the frame held exactly 32 falling serial-clock edges.

The serial clock and frame sync are sampled by the block's own clock, which must run well above the serial clock. Lane vectors use index 0 for lane A, 1 for lane B and 2 for lane C.

Top module: `serial_result_shifter`

## Requirements
- R1: The first clock after frame sync is seen low starts a frame. From then on, each selected lane drives bit 15 of its first word, before any serial-clock edge.
- R2: While frame sync is high, all three bits of `sdo_oe` are low, one clock after frame sync rises at the latest.
- R3: A lane's data changes only after a rising serial-clock edge and never on a falling one. Each word goes out MSB first, 16 bits per word.
- R4: `lane_sel` is captured at the start of a frame, and bit g of `sdo_oe` is high during that frame only if lane g was selected then. Changes to `lane_sel` during the frame have no effect.
- R5: With `lane_sel[1]` and `lane_sel[2]` both high, lane A sends A0 then A1, lane B sends B0 then B1, and lane C sends C0 then C1.
- R6: With lane B selected and lane C not, lane A sends A0, A1, C0 and lane B sends B0, B1, C1.
- R7: With lanes B and C both deselected, lane A sends A0, A1, B0, B1, C0, C1 in that order.
- R8: With lane C selected and lane B not, lane A sends A0, A1, B0, B1 and lane C sends C0, C1.
- R9: With `chain_en` high at frame start, a selected lane that has sent L local bits then sends, from bit L on, the bits captured from its chain input on successive falling serial-clock edges. The first of these is the bit captured on the frame's first falling edge.
- R10: With `chain_en` low at frame start, a lane sends 0 after its local bits, whatever its chain input does.
- R11: `sdi` is captured on each falling serial-clock edge of a frame, and the first bit received lands in bit 31. When frame sync rises, `ctrl` takes the captured word if the frame held exactly 32 falling edges. Otherwise `ctrl` keeps its value.
- R12: After reset, `ctrl` equals 0x000003FF and all output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial interface |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock |
| fs | input | 1 | Frame sync, low during a frame |
| lane_sel | input | 3 | Lane selects, bit 0 = A (must be high), 1 = B, 2 = C |
| chain_en | input | 1 | Enables forwarding of chain inputs |
| chain_in | input | 3 | Chain data inputs per lane |
| sdi | input | 1 | Serial control-word input |
| res_a0 | input | 16 | Result of channel A0 |
| res_a1 | input | 16 | Result of channel A1 |
| res_b0 | input | 16 | Result of channel B0 |
| res_b1 | input | 16 | Result of channel B1 |
| res_c0 | input | 16 | Result of channel C0 |
| res_c1 | input | 16 | Result of channel C1 |
| sdo | output | 3 | Serial data per lane |
| sdo_oe | output | 3 | Output enable per lane (low = high impedance) |
| ctrl | output | 32 | Control word committed from `sdi` |

## Verification
The bench runs a frame for each of the four lane-select combinations and compares every bit of every lane against a model of the channel-to-lane map. If the map for the partially deselected cases is wrong, C0 or C1 shows up on the wrong lane or out of order. Chain frames check that the forwarded stream starts at the first captured bit: an off-by-one tap would drop or duplicate an upstream bit, and a design that ignored `chain_en` would leak chain data into the zero tail. Frames of 31, 32 and 33 falling edges confirm that only an exact count commits the control word. Each frame also changes `lane_sel` after the frame has started, so a design that decoded the selects live would change its enables mid-frame.

// File: rtl/serial_result_shifter.sv
module serial_result_shifter #(
  parameter int RES_W = 16,
  parameter int CTRL_W = 32,
  parameter logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(32'h0000_03FF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fs,
  input  logic [2:0]        lane_sel,
  input  logic              chain_en,
  input  logic [2:0]        chain_in,
  input  logic              sdi,
  input  logic [RES_W-1:0]  res_a0,
  input  logic [RES_W-1:0]  res_a1,
  input  logic [RES_W-1:0]  res_b0,
  input  logic [RES_W-1:0]  res_b1,
  input  logic [RES_W-1:0]  res_c0,
  input  logic [RES_W-1:0]  res_c1,
  output logic [2:0]        sdo,
  output logic [2:0]        sdo_oe,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int NCH  = 6;
  localparam int SH_W = NCH * RES_W;
  localparam int IW   = $clog2(SH_W);
  localparam int CW   = $clog2(CTRL_W + 2);

  logic fs_q, sclk_q, act, dcen_q;
  logic [2:0] sel_q;

  wire fs_fall   = fs_q & ~fs;
  wire fs_rise   = ~fs_q & fs;
  wire sclk_rise = ~sclk_q & sclk;
  wire sclk_fall = sclk_q & ~sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b1;
      sclk_q <= 1'b0;
      act    <= 1'b0;
      sel_q  <= 3'b000;
      dcen_q <= 1'b0;
    end else begin
      fs_q   <= fs;
      sclk_q <= sclk;
      act    <= ~fs;
      if (fs_fall) begin
        sel_q  <= lane_sel;
        dcen_q <= chain_en;
      end
    end
  end

  logic [SH_W-1:0] ld_d [3];
  logic [2:0]      ld_n [3];

  always_comb begin
    ld_d[0] = '0; ld_d[1] = '0; ld_d[2] = '0;
    ld_n[0] = 3'd1; ld_n[1] = 3'd1; ld_n[2] = 3'd1;
    case ({lane_sel[2], lane_sel[1]})
      2'b11: begin
        ld_d[0] = SH_W'({res_a0, res_a1}); ld_n[0] = 3'd2;
        ld_d[1] = SH_W'({res_b0, res_b1}); ld_n[1] = 3'd2;
        ld_d[2] = SH_W'({res_c0, res_c1}); ld_n[2] = 3'd2;
      end
      2'b01: begin
        ld_d[0] = SH_W'({res_a0, res_a1, res_c0}); ld_n[0] = 3'd3;
        ld_d[1] = SH_W'({res_b0, res_b1, res_c1}); ld_n[1] = 3'd3;
      end
      2'b10: begin
        ld_d[0] = SH_W'({res_a0, res_a1, res_b0, res_b1}); ld_n[0] = 3'd4;
        ld_d[2] = SH_W'({res_c0, res_c1});                 ld_n[2] = 3'd2;
      end
      default: begin
        ld_d[0] = {res_a0, res_a1, res_b0, res_b1, res_c0, res_c1};
        ld_n[0] = 3'd6;
      end
    endcase
  end

  for (genvar g = 0; g < 3; g++) begin : g_lane
    logic [SH_W-1:0] sh;
    logic [2:0]      n_q;
    logic            dc_hold;
    logic [IW-1:0]   tap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh      <= '0;
        n_q     <= 3'd1;
        dc_hold <= 1'b0;
      end else if (fs_fall) begin
        sh      <= ld_d[g];
        n_q     <= ld_n[g];
        dc_hold <= 1'b0;
      end else if (act) begin
        if (sclk_rise) sh <= {sh[SH_W-2:0], dc_hold};
        if (sclk_fall) dc_hold <= chain_in[g] & dcen_q & sel_q[g];
      end
    end

    assign tap       = IW'(int'(n_q) * RES_W - 1);
    assign sdo[g]    = sh[tap];
    assign sdo_oe[g] = act & sel_q[g];
  end

  logic [CTRL_W-1:0] hold;
  logic [CW-1:0]     nfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      nfall <= '0;
      ctrl  <= CTRL_RESET;
    end else begin
      if (fs_fall) begin
        nfall <= '0;
      end else if (act && sclk_fall) begin
        hold <= {hold[CTRL_W-2:0], sdi};
        if (nfall != CW'(CTRL_W + 1)) nfall <= nfall + 1'b1;
      end
      if (fs_rise && nfall == CW'(CTRL_W)) ctrl <= hold;
    end
  end

  AST_IDLE_WHEN_FS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fs) |-> (sdo_oe == 3'b000)); // R2

  AST_LANE_B_FROM_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe[1]) |-> $past(lane_sel[1])); // R4

  AST_DATA_HELD_BETWEEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && !$past(sclk_rise)) |-> $stable(sdo)); // R3

  AST_CTRL_ONLY_AT_FS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(fs_rise)); // R11

  AST_CTRL_NEEDS_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fs_rise) && $past(nfall) != CW'(CTRL_W)) |-> $stable(ctrl)); // R11

endmodule

// File: tb/serial_result_shifter_bench.sv
module serial_result_shifter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic fs = 1'b1;
  logic [2:0] lane_sel = 3'b001;
  logic chain_en = 1'b0;
  logic [2:0] chain_in = 3'b000;
  logic sdi = 1'b0;
  logic [15:0] res [6];
  logic [2:0] sdo, sdo_oe;
  logic [31:0] ctrl;
  logic [31:0] exp_ctrl;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  initial begin
    res[0] = 16'h8001; res[1] = 16'h7FFE; res[2] = 16'h1234;
    res[3] = 16'hFEDC; res[4] = 16'h0F0F; res[5] = 16'hC3A5;
  end

  serial_result_shifter u_serial_result_shifter (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs(fs), .lane_sel(lane_sel),
    .chain_en(chain_en), .chain_in(chain_in), .sdi(sdi),
    .res_a0(res[0]), .res_a1(res[1]), .res_b0(res[2]), .res_b1(res[3]),
    .res_c0(res[4]), .res_c1(res[5]),
    .sdo(sdo), .sdo_oe(sdo_oe), .ctrl(ctrl)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lane_count(input int l, input logic [2:0] sel);
    case ({sel[2], sel[1]})
      2'b11: return 2;
      2'b01: return (l == 2) ? 0 : 3;
      2'b10: return (l == 0) ? 4 : (l == 2) ? 2 : 0;
      default: return (l == 0) ? 6 : 0;
    endcase
  endfunction

  function automatic int lane_chan(input int l, input int k, input logic [2:0] sel);
    case ({sel[2], sel[1]})
      2'b11: return l * 2 + k;
      2'b01: return (k == 2) ? (l == 0 ? 4 : 5) : (l == 0 ? k : 2 + k);
      2'b10: return (l == 0) ? k : 4 + k;
      default: return k;
    endcase
  endfunction

  function automatic logic up_bit(input int l, input int n);
    return 1'(((n * 37 + l * 11) >> 2) & 1);
  endfunction

  function automatic logic exp_bit(input int l, input int j, input logic [2:0] sel, input logic dce);
    int len;
    len = 16 * lane_count(l, sel);
    if (j < len) return res[lane_chan(l, j / 16, sel)][15 - (j % 16)];
    return dce ? up_bit(l, j - len) : 1'b0;
  endfunction

  task automatic run_frame(input logic [2:0] sel, input logic dce, input int nbits,
                           input logic [31:0] word, input string tag);
    lane_sel = sel;
    chain_en = dce;
    wait_clks(1);
    fs = 1'b0;
    wait_clks(3);
    lane_sel = ~sel | 3'b001;
    chain_en = ~dce;
    wait_clks(2);
    chk(sdo_oe == sel, "R1 R4 enables after frame start", {29'd0, sdo_oe}, {29'd0, sel});
    for (int j = 0; j < nbits; j++) begin
      sclk = 1'b0;
      chain_in = {up_bit(2, j), up_bit(1, j), up_bit(0, j)};
      sdi = (j < 32) ? word[31 - j] : 1'b1;
      wait_clks(3);
      for (int l = 0; l < 3; l++) begin
        if (sel[l]) begin
          logic e;
          string t;
          e = exp_bit(l, j, sel, dce);
          if (j < 16 * lane_count(l, sel)) t = $sformatf("%s lane %0d bit %0d", tag, l, j);
          else if (dce) t = $sformatf("R9 lane %0d bit %0d", l, j);
          else t = $sformatf("R10 lane %0d bit %0d", l, j);
          chk(sdo[l] == e, t, {31'd0, sdo[l]}, {31'd0, e});
        end
      end
      sclk = 1'b1;
      wait_clks(3);
    end
    fs = 1'b1;
    wait_clks(3);
    chk(sdo_oe == 3'b000, "R2 enables low after frame", {29'd0, sdo_oe}, 32'd0);
    if (nbits == 32) exp_ctrl = word;
    chk(ctrl == exp_ctrl, $sformatf("R11 ctrl after %0d edges", nbits), ctrl, exp_ctrl);
    wait_clks(3);
  endtask

  task automatic t_reset;
    chk(sdo_oe == 3'b000, "R12 enables at reset", {29'd0, sdo_oe}, 32'd0);
    chk(ctrl == 32'h0000_03FF, "R12 ctrl at reset", ctrl, 32'h0000_03FF);
    exp_ctrl = 32'h0000_03FF;
  endtask

  task automatic t_three_lanes;
    run_frame(3'b111, 1'b0, 32, 32'hC0DE_1234, "R3 R5");
  endtask

  task automatic t_two_lanes;
    run_frame(3'b011, 1'b0, 48, 32'h1111_2222, "R3 R6");
  endtask

  task automatic t_one_lane;
    run_frame(3'b001, 1'b0, 96, 32'h3333_4444, "R3 R7");
  endtask

  task automatic t_a_and_c;
    run_frame(3'b101, 1'b0, 64, 32'h5555_6666, "R3 R8");
  endtask

  task automatic t_chain;
    run_frame(3'b111, 1'b1, 56, 32'h7777_8888, "R9 R5");
    run_frame(3'b011, 1'b1, 60, 32'h9999_AAAA, "R9 R6");
    run_frame(3'b001, 1'b1, 110, 32'hBBBB_CCCC, "R9 R7");
  endtask

  task automatic t_no_chain;
    run_frame(3'b111, 1'b0, 44, 32'hDDDD_EEEE, "R10 R5");
  endtask

  task automatic t_ctrl_len;
    run_frame(3'b111, 1'b0, 31, 32'hDEAD_BEEF, "R11 R5");
    run_frame(3'b111, 1'b0, 33, 32'hFACE_0001, "R11 R5");
    run_frame(3'b111, 1'b0, 32, 32'h0BAD_F00D, "R11 R5");
  endtask

  initial begin
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(3);
    t_reset;
    t_three_lanes;
    t_two_lanes;
    t_one_lane;
    t_a_and_c;
    t_chain;
    t_no_chain;
    t_ctrl_len;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule